// File: doc/BRIEF.md
# Dual-Mode Host Bus Slave for Shared RAM and Control Registers

This block lets an external microprocessor reach two targets inside a chip: a 1024-word by 16-bit RAM that an internal engine also uses, and a small bank of word-addressed control registers. Strap inputs choose the strobe style. In the separate-strobe style, one line requests reads and the other requests writes. In the single-strobe style, one line is a data strobe of selectable polarity and the other tells read from write. Further strap inputs choose an 8-bit or 16-bit data bus and, on the 8-bit bus, which byte the even address selects.

Both host strobe lines pass through a two-flop synchroniser in the core clock domain. One access is recognised on the synchronised leading edge of each strobe assertion. At that edge the block takes a snapshot of the address, the selects, the byte lanes and the write data. When the host and the engine target the same RAM word, the engine goes first. The block then pulls an active-low busy line and holds the host operation back until the engine moves away.

Top module: `hostbus_bridge`

## Requirements
- R1: With `cfg_moto`=0, `hb_strb_a`=0 requests a read and `hb_strb_b`=0 (while `hb_strb_a`=1) requests a write.
- R2: With `cfg_moto`=1, `hb_strb_a` is a data strobe, active high when `cfg_dspol`=1 and active low when `cfg_dspol`=0. `hb_strb_b`=1 makes the access a read and 0 makes it a write.
- R3: Each strobe assertion performs exactly one access. The address, selects and write data are those present when the synchronised strobe edge is seen; later changes while the strobe is held have no effect.
- R4: With `cfg_wide`=0, only byte lane 0 carries data. The byte select is `hb_addr[0]` XOR `cfg_hifirst`: 0 selects word bits 7:0 and 1 selects bits 15:8. A write changes only the selected byte, and `hb_dout[15:8]` reads 0.
- R5: With `cfg_wide`=1, `hb_addr[0]`=0 enables lane 0 (bits 7:0) and `hb_hien_n`=0 enables lane 1 (bits 15:8). A disabled lane is not written, and it reads as 0 on `hb_dout`.
- R6: A RAM access needs both bits of `hb_msel_n` at 0, and `hb_addr[10:1]` selects the word. If the RAM and the register group are both selected, the RAM is accessed.
- R7: A register access needs `hb_psel_n`=0 and `hb_psel`=1, and `hb_addr[6:1]` selects the register. Register 0 reads `status_in` and ignores writes. For register k from 1 to 15, the implemented bits depend on k mod 4: 0 gives FFFF, 1 gives 0FFF, 2 gives 00FF and 3 gives 000F. Unimplemented bits read 0 and ignore writes. Indices 16 and above read 0. Register k drives `ctrl_q[16k-1:16k-16]`.
- R8: If the engine is accessing the same word as a pending host RAM access, `hb_busy_n` goes low and the host access waits. The host operation completes in the cycle in which `hb_busy_n` returns high. A deferred read returns the data the engine left in that word.
- R9: With neither select group complete, a strobe changes no RAM word or register and leaves `hb_dout` unchanged.
- R10: After reset, `hb_dout` is 0, `hb_busy_n` is 1 and every bit of `ctrl_q` is 0.
- R11: The engine port writes a word in one cycle. For a read, `eng_rdata` holds the word after the clock edge at which `eng_en`=1 and `eng_we`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_moto | input | 1 | Strobe style: 0 separate read/write strobes, 1 data strobe plus read/write line |
| cfg_dspol | input | 1 | Data-strobe polarity in single-strobe style: 1 active high |
| cfg_wide | input | 1 | Bus width: 0 for 8 bits, 1 for 16 bits |
| cfg_hifirst | input | 1 | 8-bit byte order: 1 means the even address selects the high byte |
| hb_strb_a | input | 1 | Read strobe, or data strobe |
| hb_strb_b | input | 1 | Write strobe, or read/write line |
| hb_addr | input | 11 | Host byte address |
| hb_hien_n | input | 1 | High byte lane enable, active low (16-bit bus) |
| hb_msel_n | input | 2 | RAM selects, both active low |
| hb_psel_n | input | 1 | Register select, active low |
| hb_psel | input | 1 | Register select, active high |
| hb_din | input | 16 | Write data from the host |
| hb_dout | output | 16 | Read data to the host, held until the next read |
| hb_busy_n | output | 1 | Low while a host RAM access is held off by the engine |
| eng_en | input | 1 | Engine RAM access enable |
| eng_we | input | 1 | Engine write (1) or read (0) |
| eng_addr | input | 10 | Engine word address |
| eng_wdata | input | 16 | Engine write data |
| eng_rdata | output | 16 | Engine read data |
| status_in | input | 16 | Live value returned by register 0 |
| ctrl_q | output | 240 | Contents of registers 1 to 15 |

## Verification
The assertions assume that the strap inputs stay constant from the start of a host access until it completes. They also assume that the host starts no new strobe while a collision holds an access back. Under these conditions a completed host write can never land on the word the engine is using in that same cycle, and busy can only drop after an engine request. The stimulus changes the straps only between accesses, with every select released and the strobe lines parked at the idle level of the new style. Every strobe is held until busy has returned high and the read pipeline has settled.

// File: rtl/hbi_pkg.sv
package hbi_pkg;

  localparam int unsigned HB_DW   = 16;
  localparam int unsigned LANE_W  = 8;
  localparam int unsigned N_LANES = HB_DW / LANE_W;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_CHK  = 1'b1
  } hbi_state_e;

  // Writable bits of register idx; register 0 is a read-only status word.
  function automatic logic [HB_DW-1:0] reg_wmask(input int unsigned idx);
    logic [HB_DW-1:0] m;
    if (idx == 0) begin
      m = '0;
    end else begin
      case (idx % 4)
        0:       m = 16'hFFFF;
        1:       m = 16'h0FFF;
        2:       m = 16'h00FF;
        default: m = 16'h000F;
      endcase
    end
    return m;
  endfunction

  // Place a word on the host data lanes for a read.
  function automatic logic [HB_DW-1:0] fmt_read(input logic [HB_DW-1:0] w,
                                                input logic             narrow,
                                                input logic             sel_hi,
                                                input logic [N_LANES-1:0] be);
    logic [HB_DW-1:0] r;
    r = '0;
    if (narrow) begin
      r[LANE_W-1:0] = sel_hi ? w[HB_DW-1:LANE_W] : w[LANE_W-1:0];
    end else begin
      for (int l = 0; l < int'(N_LANES); l++) begin
        if (be[l]) r[l*LANE_W +: LANE_W] = w[l*LANE_W +: LANE_W];
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/hbi_strobe_dec.sv
module hbi_strobe_dec
  import hbi_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic strb_a,
  input  logic strb_b,
  input  logic cfg_moto,
  input  logic cfg_dspol,
  output logic rd_go,
  output logic wr_go
);

  localparam int unsigned SYNC_N = 2;

  logic [SYNC_N-1:0] sa_q, sa_d, sb_q, sb_d;
  logic              rd_prev_q, wr_prev_q;
  logic              a_s, b_s, ds_on, rd_act, wr_act;

  always_comb begin
    sa_d = {sa_q[SYNC_N-2:0], strb_a};
    sb_d = {sb_q[SYNC_N-2:0], strb_b};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sa_q      <= '1;
      sb_q      <= '1;
      rd_prev_q <= 1'b1;
      wr_prev_q <= 1'b1;
    end else begin
      sa_q      <= sa_d;
      sb_q      <= sb_d;
      rd_prev_q <= rd_act;
      wr_prev_q <= wr_act;
    end
  end

  always_comb begin
    a_s   = sa_q[SYNC_N-1];
    b_s   = sb_q[SYNC_N-1];
    ds_on = cfg_dspol ? a_s : ~a_s;
    if (cfg_moto) begin
      rd_act = ds_on & b_s;
      wr_act = ds_on & ~b_s;
    end else begin
      rd_act = ~a_s;
      wr_act = ~b_s & a_s;
    end
    rd_go = rd_act & ~rd_prev_q;
    wr_go = wr_act & ~wr_prev_q;
  end

endmodule

// File: rtl/hbi_lane.sv
module hbi_lane
  import hbi_pkg::*;
(
  input  logic               cfg_wide,
  input  logic               cfg_hifirst,
  input  logic               a0,
  input  logic               hien_n,
  input  logic [HB_DW-1:0]   din,
  output logic [N_LANES-1:0] be,
  output logic [HB_DW-1:0]   wdata,
  output logic               sel_hi
);

  always_comb begin
    sel_hi = a0 ^ cfg_hifirst;
    if (cfg_wide) begin
      be    = {~hien_n, ~a0};
      wdata = din;
    end else begin
      be    = sel_hi ? 2'b10 : 2'b01;
      wdata = {din[LANE_W-1:0], din[LANE_W-1:0]};
    end
  end

endmodule

// File: rtl/hbi_dpram.sv
module hbi_dpram
  import hbi_pkg::*;
#(
  parameter int unsigned AW = 10
) (
  input  logic               clk,
  input  logic               h_en,
  input  logic               h_we,
  input  logic [N_LANES-1:0] h_be,
  input  logic [AW-1:0]      h_addr,
  input  logic [HB_DW-1:0]   h_wdata,
  output logic [HB_DW-1:0]   h_rdata,
  input  logic               e_en,
  input  logic               e_we,
  input  logic [AW-1:0]      e_addr,
  input  logic [HB_DW-1:0]   e_wdata,
  output logic [HB_DW-1:0]   e_rdata
);

  localparam int unsigned DEPTH = 1 << AW;

  logic [HB_DW-1:0] mem [DEPTH];
  logic [HB_DW-1:0] h_rq, e_rq;

  always_ff @(posedge clk) begin
    if (e_en) begin
      if (e_we) mem[e_addr] <= e_wdata;
      else      e_rq        <= mem[e_addr];
    end
    if (h_en) begin
      if (h_we) begin
        for (int l = 0; l < int'(N_LANES); l++) begin
          if (h_be[l]) mem[h_addr][l*LANE_W +: LANE_W] <= h_wdata[l*LANE_W +: LANE_W];
        end
      end else begin
        h_rq <= mem[h_addr];
      end
    end
  end

  assign h_rdata = h_rq;
  assign e_rdata = e_rq;

endmodule

// File: rtl/hbi_regbank.sv
module hbi_regbank
  import hbi_pkg::*;
#(
  parameter int unsigned REG_AW    = 6,
  parameter int unsigned REG_WORDS = 16
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en,
  input  logic [REG_AW-1:0]                idx,
  input  logic [N_LANES-1:0]               be,
  input  logic [HB_DW-1:0]                 wdata,
  input  logic [HB_DW-1:0]                 status_in,
  output logic [HB_DW-1:0]                 rdata,
  output logic [(REG_WORDS-1)*HB_DW-1:0]   ctrl_q
);

  logic [REG_WORDS*HB_DW-1:0] rflat;

  assign rflat[HB_DW-1:0] = status_in;

  for (genvar k = 1; k < REG_WORDS; k++) begin : g_reg
    localparam logic [HB_DW-1:0] WM = reg_wmask(k);
    logic [HB_DW-1:0] q, d, merged;
    logic             ld;

    always_comb begin
      merged = q;
      for (int l = 0; l < int'(N_LANES); l++) begin
        if (be[l]) merged[l*LANE_W +: LANE_W] = wdata[l*LANE_W +: LANE_W];
      end
      ld = wr_en && (idx == REG_AW'(k));
      d  = (q & ~WM) | (merged & WM);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (ld) q <= d;
    end

    assign rflat[k*HB_DW +: HB_DW]      = q;
    assign ctrl_q[(k-1)*HB_DW +: HB_DW] = q;
  end

  always_comb begin
    rdata = '0;
    for (int k = 0; k < int'(REG_WORDS); k++) begin
      if (int'(idx) == k) rdata = rflat[k*HB_DW +: HB_DW];
    end
  end

endmodule

// File: rtl/hostbus_bridge.sv
module hostbus_bridge
  import hbi_pkg::*;
#(
  parameter int unsigned RAM_AW    = 10,
  parameter int unsigned REG_AW    = 6,
  parameter int unsigned REG_WORDS = 16
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           cfg_moto,
  input  logic                           cfg_dspol,
  input  logic                           cfg_wide,
  input  logic                           cfg_hifirst,
  input  logic                           hb_strb_a,
  input  logic                           hb_strb_b,
  input  logic [RAM_AW:0]                hb_addr,
  input  logic                           hb_hien_n,
  input  logic [1:0]                     hb_msel_n,
  input  logic                           hb_psel_n,
  input  logic                           hb_psel,
  input  logic [HB_DW-1:0]               hb_din,
  output logic [HB_DW-1:0]               hb_dout,
  output logic                           hb_busy_n,
  input  logic                           eng_en,
  input  logic                           eng_we,
  input  logic [RAM_AW-1:0]              eng_addr,
  input  logic [HB_DW-1:0]               eng_wdata,
  output logic [HB_DW-1:0]               eng_rdata,
  input  logic [HB_DW-1:0]               status_in,
  output logic [(REG_WORDS-1)*HB_DW-1:0] ctrl_q
);

  typedef struct packed {
    logic               is_wr;
    logic               is_ram;
    logic [RAM_AW-1:0]  word;
    logic [N_LANES-1:0] be;
    logic [HB_DW-1:0]   wdata;
    logic               narrow;
    logic               sel_hi;
  } op_t;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_q;
  logic       rst_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= '0;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_n_i = rst_q[1];

  // strobe decode and lane selection
  logic               rd_go, wr_go;
  logic [N_LANES-1:0] ln_be;
  logic [HB_DW-1:0]   ln_wdata;
  logic               ln_sel_hi;

  hbi_strobe_dec i_dec (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .strb_a    (hb_strb_a),
    .strb_b    (hb_strb_b),
    .cfg_moto  (cfg_moto),
    .cfg_dspol (cfg_dspol),
    .rd_go     (rd_go),
    .wr_go     (wr_go)
  );

  hbi_lane i_lane (
    .cfg_wide    (cfg_wide),
    .cfg_hifirst (cfg_hifirst),
    .a0          (hb_addr[0]),
    .hien_n      (hb_hien_n),
    .din         (hb_din),
    .be          (ln_be),
    .wdata       (ln_wdata),
    .sel_hi      (ln_sel_hi)
  );

  // state
  hbi_state_e         state_q, state_d;
  op_t                op_q, op_d;
  logic               cap_en;
  logic               busy_q, busy_d;
  logic               rd_load_q, rd_load_d;
  logic               rd_ram_q, rd_ram_d;
  logic               rd_narrow_q, rd_narrow_d;
  logic               rd_selhi_q, rd_selhi_d;
  logic [N_LANES-1:0] rd_be_q, rd_be_d;
  logic [HB_DW-1:0]   reg_cap_q, reg_cap_d;
  logic               rd_cap_en;
  logic [HB_DW-1:0]   dout_q, dout_d;

  logic               ram_hit, reg_hit, coll, perform;
  logic               ram_h_en, reg_wr_en;
  logic [HB_DW-1:0]   ram_h_rdata, reg_rdata;

  always_comb begin
    ram_hit = ~hb_msel_n[0] & ~hb_msel_n[1];
    reg_hit = ~hb_psel_n & hb_psel & ~ram_hit;
    coll    = op_q.is_ram & eng_en & (eng_addr == op_q.word);
    perform = (state_q == ST_CHK) & ~coll;
  end

  always_comb begin
    state_d     = state_q;
    op_d        = op_q;
    cap_en      = 1'b0;
    busy_d      = busy_q;
    rd_load_d   = 1'b0;
    rd_cap_en   = 1'b0;
    rd_ram_d    = rd_ram_q;
    rd_narrow_d = rd_narrow_q;
    rd_selhi_d  = rd_selhi_q;
    rd_be_d     = rd_be_q;
    reg_cap_d   = reg_cap_q;
    case (state_q)
      ST_IDLE: begin
        if ((rd_go | wr_go) & (ram_hit | reg_hit)) begin
          cap_en       = 1'b1;
          op_d.is_wr   = wr_go;
          op_d.is_ram  = ram_hit;
          op_d.word    = hb_addr[RAM_AW:1];
          op_d.be      = ln_be;
          op_d.wdata   = ln_wdata;
          op_d.narrow  = ~cfg_wide;
          op_d.sel_hi  = ln_sel_hi;
          state_d      = ST_CHK;
        end
      end
      default: begin
        if (coll) begin
          busy_d = 1'b1;
        end else begin
          busy_d  = 1'b0;
          state_d = ST_IDLE;
          if (!op_q.is_wr) begin
            rd_load_d   = 1'b1;
            rd_cap_en   = 1'b1;
            rd_ram_d    = op_q.is_ram;
            rd_narrow_d = op_q.narrow;
            rd_selhi_d  = op_q.sel_hi;
            rd_be_d     = op_q.be;
            reg_cap_d   = reg_rdata;
          end
        end
      end
    endcase
  end

  always_comb begin
    dout_d = dout_q;
    if (rd_load_q) begin
      dout_d = fmt_read(rd_ram_q ? ram_h_rdata : reg_cap_q, rd_narrow_q, rd_selhi_q, rd_be_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      state_q     <= ST_IDLE;
      op_q        <= '0;
      busy_q      <= 1'b0;
      rd_load_q   <= 1'b0;
      rd_ram_q    <= 1'b0;
      rd_narrow_q <= 1'b0;
      rd_selhi_q  <= 1'b0;
      rd_be_q     <= '0;
      reg_cap_q   <= '0;
      dout_q      <= '0;
    end else begin
      state_q   <= state_d;
      busy_q    <= busy_d;
      rd_load_q <= rd_load_d;
      dout_q    <= dout_d;
      if (cap_en) op_q <= op_d;
      if (rd_cap_en) begin
        rd_ram_q    <= rd_ram_d;
        rd_narrow_q <= rd_narrow_d;
        rd_selhi_q  <= rd_selhi_d;
        rd_be_q     <= rd_be_d;
        reg_cap_q   <= reg_cap_d;
      end
    end
  end

  assign ram_h_en  = perform & op_q.is_ram;
  assign reg_wr_en = perform & ~op_q.is_ram & op_q.is_wr;

  hbi_dpram #(.AW(RAM_AW)) i_ram (
    .clk     (clk),
    .h_en    (ram_h_en),
    .h_we    (op_q.is_wr),
    .h_be    (op_q.be),
    .h_addr  (op_q.word),
    .h_wdata (op_q.wdata),
    .h_rdata (ram_h_rdata),
    .e_en    (eng_en),
    .e_we    (eng_we),
    .e_addr  (eng_addr),
    .e_wdata (eng_wdata),
    .e_rdata (eng_rdata)
  );

  hbi_regbank #(.REG_AW(REG_AW), .REG_WORDS(REG_WORDS)) i_regs (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .wr_en     (reg_wr_en),
    .idx       (op_q.word[REG_AW-1:0]),
    .be        (op_q.be),
    .wdata     (op_q.wdata),
    .status_in (status_in),
    .rdata     (reg_rdata),
    .ctrl_q    (ctrl_q)
  );

  assign hb_dout   = dout_q;
  assign hb_busy_n = ~busy_q;

endmodule

// File: rtl/hbi_chk.sv
module hbi_chk
  import hbi_pkg::*;
#(
  parameter int unsigned RAM_AW = 10
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cfg_wide,
  input logic               hb_busy_n,
  input logic               eng_en,
  input logic [RAM_AW-1:0]  eng_addr,
  input logic               h_en,
  input logic               h_we,
  input logic [RAM_AW-1:0]  h_addr,
  input logic [N_LANES-1:0] h_be
);

  // R8: a host write never lands on the word the engine uses that cycle
  a_r8_no_shared_write: assert property (@(posedge clk) disable iff (!rst_n)
    (h_en && h_we) |-> !(eng_en && (eng_addr == h_addr)));

  // R8: busy only falls after an engine request
  a_r8_busy_from_engine: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hb_busy_n) |-> $past(eng_en));

  // R8: busy releases exactly when the held host access is performed
  a_r8_release_performs: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hb_busy_n) |-> $past(h_en));

  // R3: one strobe gives one RAM operation, never two in a row
  a_r3_single_op: assert property (@(posedge clk) disable iff (!rst_n)
    h_en |=> !h_en);

  // R4: on the 8-bit bus exactly one byte lane is used
  a_r4_one_lane: assert property (@(posedge clk) disable iff (!rst_n)
    (h_en && !cfg_wide) |-> ($countones(h_be) == 1));

endmodule

bind hostbus_bridge hbi_chk #(.RAM_AW(RAM_AW)) i_hbi_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_wide  (cfg_wide),
  .hb_busy_n (hb_busy_n),
  .eng_en    (eng_en),
  .eng_addr  (eng_addr),
  .h_en      (ram_h_en),
  .h_we      (op_q.is_wr),
  .h_addr    (op_q.word),
  .h_be      (op_q.be)
);

// File: tb/test_hostbus_bridge.sv
module test_hostbus_bridge;

  localparam int RAM_AW    = 10;
  localparam int REG_WORDS = 16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_moto, cfg_dspol, cfg_wide, cfg_hifirst;
  logic        hb_strb_a, hb_strb_b;
  logic [10:0] hb_addr;
  logic        hb_hien_n;
  logic [1:0]  hb_msel_n;
  logic        hb_psel_n, hb_psel;
  logic [15:0] hb_din, hb_dout;
  logic        hb_busy_n;
  logic        eng_en, eng_we;
  logic [9:0]  eng_addr;
  logic [15:0] eng_wdata, eng_rdata;
  logic [15:0] status_in;
  logic [239:0] ctrl_q;

  hostbus_bridge i_hostbus_bridge (
    .clk(clk), .rst_n(rst_n), .cfg_moto(cfg_moto), .cfg_dspol(cfg_dspol),
    .cfg_wide(cfg_wide), .cfg_hifirst(cfg_hifirst), .hb_strb_a(hb_strb_a),
    .hb_strb_b(hb_strb_b), .hb_addr(hb_addr), .hb_hien_n(hb_hien_n),
    .hb_msel_n(hb_msel_n), .hb_psel_n(hb_psel_n), .hb_psel(hb_psel),
    .hb_din(hb_din), .hb_dout(hb_dout), .hb_busy_n(hb_busy_n),
    .eng_en(eng_en), .eng_we(eng_we), .eng_addr(eng_addr),
    .eng_wdata(eng_wdata), .eng_rdata(eng_rdata), .status_in(status_in),
    .ctrl_q(ctrl_q)
  );

  always #2 clk = ~clk;

  int n_chk  = 0;
  int n_fail = 0;

  logic [15:0] mem_m [1024];
  logic [15:0] reg_m [REG_WORDS];
  logic [9:0]  words [16];

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_rd(input logic [15:0] w, input bit wide, input bit hif,
                                         input bit a0, input bit hien_n);
    if (!wide) return {8'h00, (a0 ^ hif) ? w[15:8] : w[7:0]};
    return {hien_n ? 8'h00 : w[15:8], a0 ? 8'h00 : w[7:0]};
  endfunction

  function automatic logic [15:0] exp_wr(input logic [15:0] old, input bit wide, input bit hif,
                                         input bit a0, input bit hien_n, input logic [15:0] din);
    logic [15:0] r = old;
    if (!wide) begin
      if (a0 ^ hif) r[15:8] = din[7:0];
      else          r[7:0]  = din[7:0];
    end else begin
      if (!hien_n) r[15:8] = din[15:8];
      if (!a0)     r[7:0]  = din[7:0];
    end
    return r;
  endfunction

  function automatic logic [15:0] mask_of(input int idx);
    if (idx == 0) return 16'h0000;
    case (idx % 4)
      0: return 16'hFFFF;
      1: return 16'h0FFF;
      2: return 16'h00FF;
      default: return 16'h000F;
    endcase
  endfunction

  function automatic logic [15:0] reg_exp(input int idx);
    if (idx == 0) return status_in;
    if (idx < REG_WORDS) return reg_m[idx];
    return 16'h0000;
  endfunction

  function automatic string style_tag();
    return cfg_moto ? "R2" : "R1";
  endfunction

  function automatic string lane_tag();
    return cfg_wide ? "R5" : "R4";
  endfunction

  task automatic idle_lines();
    hb_strb_a = (cfg_moto && cfg_dspol) ? 1'b0 : 1'b1;
    hb_strb_b = 1'b1;
  endtask

  task automatic set_mode(input bit moto, input bit pol, input bit wide, input bit hif);
    @(negedge clk);
    hb_msel_n = 2'b11; hb_psel_n = 1'b1; hb_psel = 1'b0;
    cfg_moto = moto; cfg_dspol = pol; cfg_wide = wide; cfg_hifirst = hif;
    idle_lines();
    repeat (4) @(negedge clk);
  endtask

  // one host access; msel/psel given directly, optional din change while held
  task automatic access(input bit is_wr, input logic [1:0] msel, input bit psel_on,
                        input logic [10:0] a, input bit hien_n, input logic [15:0] din,
                        input bit late_chg, input logic [15:0] din2);
    @(negedge clk);
    hb_addr = a; hb_hien_n = hien_n; hb_din = din;
    hb_msel_n = msel; hb_psel_n = ~psel_on; hb_psel = psel_on;
    if (cfg_moto) hb_strb_b = is_wr ? 1'b0 : 1'b1;
    @(negedge clk);
    if (cfg_moto)   hb_strb_a = cfg_dspol;
    else if (is_wr) hb_strb_b = 1'b0;
    else            hb_strb_a = 1'b0;
    repeat (8) @(negedge clk);
    if (late_chg) hb_din = din2;
    while (!hb_busy_n) @(negedge clk);
    repeat (4) @(negedge clk);
    idle_lines();
    @(negedge clk);
    hb_msel_n = 2'b11; hb_psel_n = 1'b1; hb_psel = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic ram_wr(input logic [9:0] w, input bit a0, input bit hien_n, input logic [15:0] din);
    access(1'b1, 2'b00, 1'b0, {w, a0}, hien_n, din, 1'b0, 16'h0);
    mem_m[w] = exp_wr(mem_m[w], cfg_wide, cfg_hifirst, a0, hien_n, din);
  endtask

  task automatic ram_rd(input logic [9:0] w, input bit a0, input bit hien_n, input string tag);
    access(1'b0, 2'b00, 1'b0, {w, a0}, hien_n, 16'h0, 1'b0, 16'h0);
    check(tag, hb_dout, exp_rd(mem_m[w], cfg_wide, cfg_hifirst, a0, hien_n));
  endtask

  task automatic reg_wr(input int idx, input bit a0, input bit hien_n, input logic [15:0] din);
    logic [9:0] w = 10'(idx);
    access(1'b1, 2'b11, 1'b1, {w, a0}, hien_n, din, 1'b0, 16'h0);
    if (idx > 0 && idx < REG_WORDS)
      reg_m[idx] = (reg_m[idx] & ~mask_of(idx)) |
                   (exp_wr(reg_m[idx], cfg_wide, cfg_hifirst, a0, hien_n, din) & mask_of(idx));
  endtask

  task automatic reg_rd(input int idx, input bit a0, input bit hien_n, input string tag);
    logic [9:0] w = 10'(idx);
    access(1'b0, 2'b11, 1'b1, {w, a0}, hien_n, 16'h0, 1'b0, 16'h0);
    check(tag, hb_dout, exp_rd(reg_exp(idx), cfg_wide, cfg_hifirst, a0, hien_n));
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd4242));
    rst_n = 1'b0;
    cfg_moto = 1'b0; cfg_dspol = 1'b0; cfg_wide = 1'b1; cfg_hifirst = 1'b0;
    hb_strb_a = 1'b1; hb_strb_b = 1'b1; hb_addr = '0; hb_hien_n = 1'b1;
    hb_msel_n = 2'b11; hb_psel_n = 1'b1; hb_psel = 1'b0; hb_din = '0;
    eng_en = 1'b0; eng_we = 1'b0; eng_addr = '0; eng_wdata = '0;
    status_in = 16'hA5C3;
    for (int k = 0; k < REG_WORDS; k++) reg_m[k] = 16'h0;
    for (int k = 0; k < 16; k++) words[k] = 10'(k * 61 + 3);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R10 reset state
    check("R10 dout", hb_dout, 16'h0000);
    check("R10 busy_n", {15'h0, hb_busy_n}, 16'h0001);
    check("R10 ctrl_q", (ctrl_q == '0) ? 16'h0 : 16'h1, 16'h0);

    // fill the working words, separate-strobe 16-bit
    set_mode(1'b0, 1'b0, 1'b1, 1'b0);
    for (int k = 0; k < 16; k++) ram_wr(words[k], 1'b0, 1'b0, 16'(k * 16'h1111 + 16'h0101));
    ram_rd(words[3], 1'b0, 1'b0, "R1/R5/R6 full word");
    ram_rd(words[4], 1'b1, 1'b0, "R5 high lane only");
    ram_rd(words[5], 1'b0, 1'b1, "R5 low lane only");

    // R3: data changed while the strobe is held must not be used
    access(1'b1, 2'b00, 1'b0, {words[6], 1'b0}, 1'b0, 16'h1234, 1'b1, 16'hDEAD);
    mem_m[words[6]] = 16'h1234;
    ram_rd(words[6], 1'b0, 1'b0, "R3 held strobe first data");

    // R9: incomplete selects leave RAM and registers untouched
    access(1'b1, 2'b01, 1'b0, {words[7], 1'b0}, 1'b0, 16'hBEEF, 1'b0, 16'h0);
    access(1'b1, 2'b11, 1'b0, {words[7], 1'b0}, 1'b0, 16'hBEEF, 1'b0, 16'h0);
    ram_rd(words[7], 1'b0, 1'b0, "R9 partial select ignored");
    hb_psel_n = 1'b1;
    access(1'b1, 2'b11, 1'b0, 11'h00A, 1'b0, 16'hFFFF, 1'b0, 16'h0);
    reg_rd(5, 1'b0, 1'b0, "R9 register untouched");

    // R7: masks, read-only status, out-of-range
    reg_wr(2, 1'b0, 1'b0, 16'hFFFF);
    reg_rd(2, 1'b0, 1'b0, "R7 reg2 mask 00FF");
    reg_wr(3, 1'b0, 1'b0, 16'hFFFF);
    reg_rd(3, 1'b0, 1'b0, "R7 reg3 mask 000F");
    reg_wr(4, 1'b0, 1'b0, 16'hC0DE);
    reg_rd(4, 1'b0, 1'b0, "R7 reg4 full");
    check("R7 ctrl_q reg4", ctrl_q[3*16 +: 16], 16'hC0DE);
    reg_wr(0, 1'b0, 1'b0, 16'h0000);
    reg_rd(0, 1'b0, 1'b0, "R7 reg0 read-only status");
    status_in = 16'h5A3C;
    reg_rd(0, 1'b0, 1'b0, "R7 reg0 follows status");
    reg_wr(20, 1'b0, 1'b0, 16'hFFFF);
    reg_rd(20, 1'b0, 1'b0, "R7 index beyond bank");

    // R6: both groups selected goes to RAM
    access(1'b1, 2'b00, 1'b1, {10'd5, 1'b0}, 1'b0, 16'h7777, 1'b0, 16'h0);
    mem_m[5] = 16'h7777;
    ram_rd(10'd5, 1'b0, 1'b0, "R6 RAM wins");
    reg_rd(5, 1'b0, 1'b0, "R6 register kept");

    // R4: 8-bit byte order both ways
    set_mode(1'b0, 1'b0, 1'b0, 1'b0);
    ram_wr(words[8], 1'b1, 1'b1, 16'h00AB);
    ram_rd(words[8], 1'b1, 1'b1, "R4 low-first odd=high");
    ram_rd(words[8], 1'b0, 1'b1, "R4 low-first even=low");
    set_mode(1'b0, 1'b0, 1'b0, 1'b1);
    ram_wr(words[8], 1'b1, 1'b1, 16'h00CD);
    ram_rd(words[8], 1'b0, 1'b1, "R4 high-first even=high");
    ram_rd(words[8], 1'b1, 1'b1, "R4 high-first odd=low");

    // R2: single strobe both polarities
    set_mode(1'b1, 1'b1, 1'b1, 1'b0);
    ram_wr(words[9], 1'b0, 1'b0, 16'h9A9A);
    ram_rd(words[9], 1'b0, 1'b0, "R2 strobe active high");
    set_mode(1'b1, 1'b0, 1'b1, 1'b0);
    ram_wr(words[9], 1'b0, 1'b0, 16'h4B4B);
    ram_rd(words[9], 1'b0, 1'b0, "R2 strobe active low");

    // R8 and R11: collisions with the engine
    set_mode(1'b0, 1'b0, 1'b1, 1'b0);
    @(negedge clk);
    eng_en = 1'b1; eng_we = 1'b1; eng_addr = words[10]; eng_wdata = 16'hE0E0;
    fork
      ram_wr(words[10], 1'b0, 1'b0, 16'h0F0F);
      begin
        repeat (12) @(negedge clk);
        check("R8 busy during write collision", {15'h0, hb_busy_n}, 16'h0000);
        eng_en = 1'b0;
      end
    join
    ram_rd(words[10], 1'b0, 1'b0, "R8 deferred host write lands");
    @(negedge clk);
    eng_en = 1'b1; eng_we = 1'b1; eng_addr = words[11]; eng_wdata = 16'h6E6E;
    fork
      ram_rd(words[11], 1'b0, 1'b0, "R8 deferred read");
      begin
        mem_m[words[11]] = 16'h6E6E;
        repeat (12) @(negedge clk);
        check("R8 busy during read collision", {15'h0, hb_busy_n}, 16'h0000);
        eng_en = 1'b0;
      end
    join
    check("R8 busy released", {15'h0, hb_busy_n}, 16'h0001);
    @(negedge clk);
    eng_en = 1'b1; eng_we = 1'b0; eng_addr = words[12];
    @(negedge clk);
    eng_en = 1'b0;
    check("R11 engine read", eng_rdata, mem_m[words[12]]);
    @(negedge clk);
    eng_en = 1'b1; eng_we = 1'b1; eng_addr = words[13]; eng_wdata = 16'h3C3C;
    @(negedge clk);
    eng_en = 1'b0;
    mem_m[words[13]] = 16'h3C3C;
    ram_rd(words[13], 1'b0, 1'b0, "R11 engine write seen by host");

    // constrained random mix
    for (int it = 0; it < 160; it++) begin
      if (it % 16 == 0) begin
        logic [3:0] m;
        m = 4'($urandom);
        set_mode(m[0], m[1], m[2], m[3]);
      end
      begin
        int r;
        bit a0, hn;
        logic [15:0] d;
        r  = int'($urandom % 100);
        a0 = 1'($urandom);
        hn = 1'($urandom);
        d  = 16'($urandom);
        if (r < 35) begin
          ram_wr(words[$urandom % 16], a0, hn, d);
        end else if (r < 70) begin
          ram_rd(words[$urandom % 16], a0, hn,
                 $sformatf("%s/%s random RAM read", style_tag(), lane_tag()));
        end else if (r < 85) begin
          reg_wr(int'($urandom % 24), a0, hn, d);
        end else begin
          reg_rd(int'($urandom % 24), a0, hn,
                 $sformatf("R7/%s random register read", lane_tag()));
        end
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule